// File: doc/BRIEF.md
# Leaf PTE Accessed/Dirty Bit Updater

This block takes over a leaf page-table entry once a table walk has finished. It receives the entry, the entry's physical address and the kind of access (load, store or instruction fetch). It then decides whether the accessed (A) and dirty (D) flags in that entry are already good enough for the access. A static mode input selects one of two policies. In the trapping policy, a missing flag becomes a page-fault result, and the block issues no memory traffic. In the hardware policy, the block sets the missing flags itself. It does this as a compare-and-swap over a simple request/response memory port, and it re-reads and re-validates the entry inside that operation.

The block handles one request at a time, accepted through a valid/ready handshake. It reports one of three results and holds it until the consumer acknowledges it: grant (the original access may proceed), page fault, or retry-exhausted. Setting only A may happen on behalf of a speculative access. Setting D waits for a non-speculative indication. The grant never appears before the memory has acknowledged the entry write. An abort that arrives after the write has completed drops the access, and the flags already written stay set.

Top module: `pte_ad_updater`

## Requirements
- R1: With `hw_update_en` low, an access to a leaf whose A bit (bit 6) is clear, or a store (`req_kind` 1) to a leaf whose D bit (bit 7) is clear, ends in `fault`, and the block makes no memory request.
- R2: With `hw_update_en` high, a valid leaf that lacks a flag is written once to `req_addr`. The written value is the entry with A set, and also with D set when the access is a store. The write carries the previously read value in `mem_req_cmp`, and all other bits are unchanged.
- R3: A leaf is valid only when V (bit 0) is 1, R (bit 1) or X (bit 3) is 1, the combination W (bit 2) = 1 with R = 0 is absent, and the access right is present. A load (`req_kind` 0) needs R, a store (kind 1) needs W, and a fetch (kind 2) needs X. An invalid leaf ends in `fault` without a write.
- R4: In the hardware policy, the entry is re-read from memory before any write, and the checks of R3 are repeated on the value read. If they fail, the result is `fault` and nothing is written.
- R5: When the flags the access needs are already set, either in the walker's entry or in the re-read value, the result is `grant` with no memory write.
- R6: An update that sets only A proceeds whether or not `nonspec` is high. An update that must set D stalls, with no memory request, until `nonspec` is high.
- R7: `grant` stays low until the write response has arrived without mismatch. Once raised, a result holds until `res_ack`.
- R8: A write response with `mem_rsp_fail` restarts from the re-read. After `MAX_TRIES` failed writes the result is `retry_fail`, and the entry in memory is left as it was.
- R9: `abort` during a D-update stall drops the request with no write. `abort` while `grant` is high drops the access, returns to idle and issues no further memory request; the written flags stay set.
- R10: `req_ready` is high only when the block is idle with no result pending. It is high after reset.
- R11: A memory request that has not been accepted keeps its valid, address, write flag and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_update_en | input | 1 | Static policy: 1 sets flags in hardware, 0 traps |
| nonspec | input | 1 | The pending store is non-speculative |
| abort | input | 1 | Drop the pending access (stall or grant) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when valid |
| req_pte | input | PTE_W | Leaf entry from the walker |
| req_addr | input | PA_W | Physical address of the entry |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 conditional write, 0 read |
| mem_req_addr | output | PA_W | Entry address |
| mem_req_wdata | output | PTE_W | New entry value |
| mem_req_cmp | output | PTE_W | Expected current value for the swap |
| mem_rsp_valid | input | 1 | Response valid, at least one cycle after acceptance |
| mem_rsp_data | input | PTE_W | Read data |
| mem_rsp_fail | input | 1 | Conditional write mismatched |
| grant | output | 1 | Original access may proceed |
| fault | output | 1 | Page fault |
| retry_fail | output | 1 | Swap attempts exhausted |
| res_ack | input | 1 | Consumer takes the result |

## Verification
Some properties hold on every cycle, and assertions check them. In trapping mode the memory port stays silent. Every conditional write differs from its compare value only by newly set A/D bits, and it only ever targets a valid leaf. A write that newly sets D is never issued while the store is still speculative. The grant never overlaps an outstanding write, at most one result is shown at a time, and a stalled memory request holds steady. Other behaviour only the bench scenarios can show. These are the exact flag arithmetic over every low-byte entry pattern, access kind and policy, and a leaf that goes invalid between the walk and the re-read. They also cover an entry already updated by another agent, recovery from swap mismatch and exhaustion, and both abort points.

// File: rtl/pte_ad_pkg.sv
package pte_ad_pkg;

   localparam int unsigned BIT_V = 0;
   localparam int unsigned BIT_R = 1;
   localparam int unsigned BIT_W = 2;
   localparam int unsigned BIT_X = 3;
   localparam int unsigned BIT_U = 4;
   localparam int unsigned BIT_G = 5;
   localparam int unsigned BIT_A = 6;
   localparam int unsigned BIT_D = 7;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_READ,
      S_CHECK,
      S_WRITE,
      S_WAIT_ACK,
      S_DONE,
      S_FAULT
   } upd_state_t;

endpackage

// File: rtl/pte_ad_eval.sv
module pte_ad_eval
   import pte_ad_pkg::*;
#(
   parameter int unsigned PTE_W = 64
)(
   input  logic [PTE_W-1:0] pte,
   input  logic [1:0]       kind,
   output logic             leaf_ok,
   output logic             need_a,
   output logic             need_d,
   output logic [PTE_W-1:0] new_pte
);

   logic perm_ok;
   logic shape_ok;

   always_comb begin
      case (acc_t'(kind))
         ACC_LOAD:  perm_ok = pte[BIT_R];
         ACC_STORE: perm_ok = pte[BIT_W];
         ACC_FETCH: perm_ok = pte[BIT_X];
         default:   perm_ok = 1'b0;
      endcase
   end

   assign shape_ok = pte[BIT_V] && (pte[BIT_R] || pte[BIT_X])
                     && !(pte[BIT_W] && !pte[BIT_R]);
   assign leaf_ok  = shape_ok && perm_ok;
   assign need_a   = !pte[BIT_A];
   assign need_d   = (acc_t'(kind) == ACC_STORE) && !pte[BIT_D];

   always_comb begin
      new_pte        = pte;
      new_pte[BIT_A] = 1'b1;
      if (need_d)
         new_pte[BIT_D] = 1'b1;
   end

endmodule

// File: rtl/pte_ad_retry.sv
module pte_ad_retry #(
   parameter int unsigned MAX_TRIES = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bump,
   output logic last
);

   generate
      if (MAX_TRIES == 1) begin : g_single
         assign last = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(MAX_TRIES);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (clr)
               cnt <= '0;
            else if (bump && !last)
               cnt <= cnt + 1'b1;
         end

         assign last = (cnt == CW'(MAX_TRIES - 1));
      end
   endgenerate

endmodule

// File: rtl/pte_ad_updater.sv
module pte_ad_updater
   import pte_ad_pkg::*;
#(
   parameter int unsigned PTE_W     = 64,
   parameter int unsigned PA_W      = 56,
   parameter int unsigned MAX_TRIES = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_update_en,
   input  logic             nonspec,
   input  logic             abort,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [PTE_W-1:0] req_pte,
   input  logic [PA_W-1:0]  req_addr,
   input  logic [1:0]       req_kind,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic             mem_req_write,
   output logic [PA_W-1:0]  mem_req_addr,
   output logic [PTE_W-1:0] mem_req_wdata,
   output logic [PTE_W-1:0] mem_req_cmp,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   input  logic             mem_rsp_fail,
   output logic             grant,
   output logic             fault,
   output logic             retry_fail,
   input  logic             res_ack
);

   generate
      if (PTE_W < 8) begin : g_bad_width
         $error("PTE_W must hold the eight flag bits");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("MAX_TRIES must be at least one");
      end
      if (PA_W < 1) begin : g_bad_addr
         $error("PA_W must be positive");
      end
   endgenerate

   upd_state_t       state;
   logic [PTE_W-1:0] cur_pte;
   logic [PA_W-1:0]  addr_q;
   logic [1:0]       kind_q;
   logic             fresh_q;
   logic             issued_q;
   logic             why_retry_q;

   logic             leaf_ok;
   logic             need_a;
   logic             need_d;
   logic [PTE_W-1:0] new_pte;
   logic             retry_last;
   logic             retry_clr;
   logic             retry_bump;

   pte_ad_eval #(.PTE_W(PTE_W)) u_eval (
      .pte     (cur_pte),
      .kind    (kind_q),
      .leaf_ok (leaf_ok),
      .need_a  (need_a),
      .need_d  (need_d),
      .new_pte (new_pte)
   );

   assign retry_clr  = req_valid && req_ready;
   assign retry_bump = (state == S_WAIT_ACK) && mem_rsp_valid && mem_rsp_fail;

   pte_ad_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (retry_clr),
      .bump  (retry_bump),
      .last  (retry_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         cur_pte     <= '0;
         addr_q      <= '0;
         kind_q      <= '0;
         fresh_q     <= 1'b0;
         issued_q    <= 1'b0;
         why_retry_q <= 1'b0;
      end else begin
         case (state)
            S_IDLE: begin
               if (req_valid) begin
                  cur_pte     <= req_pte;
                  addr_q      <= req_addr;
                  kind_q      <= req_kind;
                  fresh_q     <= 1'b0;
                  issued_q    <= 1'b0;
                  why_retry_q <= 1'b0;
                  state       <= S_CHECK;
               end
            end
            S_CHECK: begin
               if (!leaf_ok)
                  state <= S_FAULT;
               else if (!need_a && !need_d)
                  state <= S_DONE;
               else if (!hw_update_en)
                  state <= S_FAULT;
               else if (need_d && !nonspec) begin
                  if (abort)
                     state <= S_IDLE;
               end else if (!fresh_q)
                  state <= S_READ;
               else
                  state <= S_WRITE;
            end
            S_READ: begin
               if (!issued_q) begin
                  if (mem_req_ready)
                     issued_q <= 1'b1;
               end else if (mem_rsp_valid) begin
                  cur_pte  <= mem_rsp_data;
                  fresh_q  <= 1'b1;
                  issued_q <= 1'b0;
                  state    <= S_CHECK;
               end
            end
            S_WRITE: begin
               if (mem_req_ready)
                  state <= S_WAIT_ACK;
            end
            S_WAIT_ACK: begin
               if (mem_rsp_valid) begin
                  if (!mem_rsp_fail)
                     state <= S_DONE;
                  else if (retry_last) begin
                     why_retry_q <= 1'b1;
                     state       <= S_FAULT;
                  end else begin
                     fresh_q <= 1'b0;
                     state   <= S_READ;
                  end
               end
            end
            S_DONE: begin
               if (res_ack || abort)
                  state <= S_IDLE;
            end
            S_FAULT: begin
               if (res_ack)
                  state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready     = (state == S_IDLE);
      mem_req_valid = ((state == S_READ) && !issued_q) || (state == S_WRITE);
      mem_req_write = (state == S_WRITE);
      mem_req_addr  = addr_q;
      mem_req_wdata = new_pte;
      mem_req_cmp   = cur_pte;
      grant         = (state == S_DONE);
      fault         = (state == S_FAULT) && !why_retry_q;
      retry_fail    = (state == S_FAULT) && why_retry_q;
   end

endmodule

// File: rtl/pte_ad_checker.sv
module pte_ad_checker
   import pte_ad_pkg::*;
#(
   parameter int unsigned PTE_W = 64,
   parameter int unsigned PA_W  = 56
)(
   input logic             clk,
   input logic             rst_n,
   input logic             hw_update_en,
   input logic             nonspec,
   input logic             req_valid,
   input logic             req_ready,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic             mem_req_write,
   input logic [PA_W-1:0]  mem_req_addr,
   input logic [PTE_W-1:0] mem_req_wdata,
   input logic [PTE_W-1:0] mem_req_cmp,
   input logic             mem_rsp_valid,
   input logic             grant,
   input logic             fault,
   input logic             retry_fail
);

   localparam logic [PTE_W-1:0] AD_MASK = (PTE_W'(1) << BIT_A) | (PTE_W'(1) << BIT_D);

   logic ns_seen;
   logic wr_out;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ns_seen <= 1'b0;
         wr_out  <= 1'b0;
      end else begin
         if (req_valid && req_ready)
            ns_seen <= 1'b0;
         else if (nonspec)
            ns_seen <= 1'b1;
         if (mem_req_valid && mem_req_ready && mem_req_write)
            wr_out <= 1'b1;
         else if (mem_rsp_valid)
            wr_out <= 1'b0;
      end
   end

   AST_TRAP_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_update_en |-> !mem_req_valid);                                          // R1
   AST_SWAP_ONLY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write |->
         (((mem_req_wdata ^ mem_req_cmp) & ~AD_MASK) == '0) && mem_req_wdata[BIT_A]
         && ((mem_req_wdata & mem_req_cmp) == mem_req_cmp));                    // R2
   AST_WRITE_VALID_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write |->
         mem_req_cmp[BIT_V] && !(mem_req_cmp[BIT_W] && !mem_req_cmp[BIT_R]));   // R4
   AST_DIRTY_NONSPEC: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write && mem_req_wdata[BIT_D] && !mem_req_cmp[BIT_D]
         |-> ns_seen || nonspec);                                                 // R6
   AST_GRANT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> !wr_out);                                                         // R7
   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant, fault, retry_fail}));                                      // R7
   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(grant || fault || retry_fail) && !mem_req_valid);           // R10
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=>
         mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
         && $stable(mem_req_wdata));                                              // R11

endmodule

bind pte_ad_updater pte_ad_checker #(.PTE_W(PTE_W), .PA_W(PA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .hw_update_en  (hw_update_en),
   .nonspec       (nonspec),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_write (mem_req_write),
   .mem_req_addr  (mem_req_addr),
   .mem_req_wdata (mem_req_wdata),
   .mem_req_cmp   (mem_req_cmp),
   .mem_rsp_valid (mem_rsp_valid),
   .grant         (grant),
   .fault         (fault),
   .retry_fail    (retry_fail)
);

// File: tb/pte_ad_updater_test.sv
module pte_ad_updater_test;

   localparam int PTE_W     = 16;
   localparam int PA_W      = 12;
   localparam int MAX_TRIES = 3;
   localparam int LAT       = 3;
   localparam logic [PA_W-1:0] ADDR = 12'h5A4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n, hw_update_en, nonspec, abort, req_valid, req_ready;
   logic [PTE_W-1:0] req_pte;
   logic [PA_W-1:0]  req_addr;
   logic [1:0]       req_kind;
   logic             mem_req_valid, mem_req_ready, mem_req_write;
   logic [PA_W-1:0]  mem_req_addr;
   logic [PTE_W-1:0] mem_req_wdata, mem_req_cmp, mem_rsp_data;
   logic             mem_rsp_valid, mem_rsp_fail;
   logic             grant, fault, retry_fail, res_ack;

   pte_ad_updater #(.PTE_W(PTE_W), .PA_W(PA_W), .MAX_TRIES(MAX_TRIES)) uut (
      .clk(clk), .rst_n(rst_n), .hw_update_en(hw_update_en), .nonspec(nonspec),
      .abort(abort), .req_valid(req_valid), .req_ready(req_ready), .req_pte(req_pte),
      .req_addr(req_addr), .req_kind(req_kind), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_req_cmp(mem_req_cmp), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .mem_rsp_fail(mem_rsp_fail), .grant(grant),
      .fault(fault), .retry_fail(retry_fail), .res_ack(res_ack)
   );

   // memory model holding one entry
   logic [PTE_W-1:0] mem_pte = '0;
   logic [PTE_W-1:0] host_pte = '0;
   int               host_fail = 0;
   int               host_seq = 0;
   int               seen_seq = 0;
   int               fail_budget = 0;
   logic             choppy = 1'b0;
   logic             busy = 1'b0;
   int               lat_cnt = 0;
   logic             pend_wr = 1'b0;
   logic [PTE_W-1:0] pend_wd = '0, pend_cmp = '0;
   logic [PA_W-1:0]  last_addr = '0;
   int               n_rd = 0, n_wr = 0;
   int unsigned      cyc = 0;
   logic             wr_out = 1'b0;

   initial begin
      mem_rsp_valid = 1'b0;
      mem_rsp_fail  = 1'b0;
      mem_rsp_data  = '0;
      mem_req_ready = 1'b1;
   end

   always @(posedge clk) begin
      cyc           <= cyc + 1;
      mem_rsp_valid <= 1'b0;
      mem_rsp_fail  <= 1'b0;
      mem_req_ready <= choppy ? (cyc % 3 != 0) : 1'b1;
      if (host_seq != seen_seq) begin
         seen_seq    <= host_seq;
         mem_pte     <= host_pte;
         fail_budget <= host_fail;
      end else if (busy) begin
         if (lat_cnt == 1) begin
            busy          <= 1'b0;
            wr_out        <= 1'b0;
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem_pte;
            if (pend_wr) begin
               if (fail_budget > 0) begin
                  mem_rsp_fail <= 1'b1;
                  fail_budget  <= fail_budget - 1;
               end else if (pend_cmp == mem_pte)
                  mem_pte <= pend_wd;
               else
                  mem_rsp_fail <= 1'b1;
            end
         end else
            lat_cnt <= lat_cnt - 1;
      end else if (mem_req_valid && mem_req_ready) begin
         busy      <= 1'b1;
         lat_cnt   <= LAT;
         pend_wr   <= mem_req_write;
         pend_wd   <= mem_req_wdata;
         pend_cmp  <= mem_req_cmp;
         last_addr <= mem_req_addr;
         if (mem_req_write) begin
            n_wr   <= n_wr + 1;
            wr_out <= 1'b1;
         end else
            n_rd <= n_rd + 1;
      end
   end

   // monitors
   int viol_ack = 0;
   int viol_ready = 0;
   always @(negedge clk) begin
      if (rst_n && grant && wr_out) viol_ack <= viol_ack + 1;
      if (rst_n && req_ready && (grant || fault || retry_fail)) viol_ready <= viol_ready + 1;
   end

   int checks = 0;
   int errors = 0;

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic host_set(input logic [PTE_W-1:0] p, input int f);
      host_pte  = p;
      host_fail = f;
      host_seq++;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic issue(input logic [PTE_W-1:0] p, input int k);
      req_valid = 1'b1;
      req_pte   = p;
      req_addr  = ADDR;
      req_kind  = 2'(k);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // 0 none, 1 grant, 2 fault, 3 retry_fail
   task automatic wait_res(output int code);
      code = 0;
      for (int i = 0; i < 300 && code == 0; i++) begin
         if (grant) code = 1;
         else if (fault) code = 2;
         else if (retry_fail) code = 3;
         else @(negedge clk);
      end
   endtask

   task automatic release_res();
      res_ack = 1'b1;
      @(negedge clk);
      res_ack = 1'b0;
   endtask

   function automatic logic leaf_valid(input logic [7:0] b, input int k);
      if (!b[0]) return 1'b0;
      if (b[2] && !b[1]) return 1'b0;
      if (!(b[1] || b[3])) return 1'b0;
      case (k)
         0: return b[1];
         1: return b[2];
         default: return b[3];
      endcase
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
   end

   initial begin
      int code, wr0, rd0;
      logic [PTE_W-1:0] p, exp_mem;
      rst_n = 1'b0; hw_update_en = 1'b0; nonspec = 1'b1; abort = 1'b0;
      req_valid = 1'b0; req_pte = '0; req_addr = '0; req_kind = '0; res_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
      chk({grant, fault, retry_fail, mem_req_valid} == 4'b0, "R10 outputs idle after reset",
          int'({grant, fault, retry_fail, mem_req_valid}), 0);

      // sweep: both policies, all kinds, all low-byte patterns
      for (int mode = 0; mode < 2; mode++) begin
         hw_update_en = mode[0];
         choppy       = mode[0];
         for (int k = 0; k < 3; k++) begin
            for (int lo = 0; lo < 256; lo++) begin
               logic v, need;
               int exp_code;
               string tag;
               p = {8'hC3, 8'(lo)};
               host_set(p, 0);
               wr0 = n_wr;
               issue(p, k);
               wait_res(code);
               release_res();
               v    = leaf_valid(8'(lo), k);
               need = !p[6] || (k == 1 && !p[7]);
               exp_mem = p;
               if (!v) begin exp_code = 2; tag = "R3"; end
               else if (!need) begin exp_code = 1; tag = "R5"; end
               else if (mode == 0) begin exp_code = 2; tag = "R1"; end
               else begin
                  exp_code = 1; tag = "R2";
                  exp_mem = p | 16'h0040 | ((k == 1) ? 16'h0080 : 16'h0000);
               end
               chk(code == exp_code, {tag, " result"}, code, exp_code);
               chk((n_wr - wr0) == ((mode == 1 && v && need) ? 1 : 0), {tag, " write count"},
                   n_wr - wr0, (mode == 1 && v && need) ? 1 : 0);
               chk(mem_pte == exp_mem, {tag, " entry value"}, int'(mem_pte), int'(exp_mem));
               if (mode == 1 && v && need)
                  chk(last_addr == ADDR, "R2 write address", int'(last_addr), int'(ADDR));
            end
         end
      end

      hw_update_en = 1'b1;
      choppy       = 1'b0;

      // R6: store needing D stalls while speculative, no write
      p = 16'hC347;
      host_set(p, 0);
      wr0 = n_wr; rd0 = n_rd;
      nonspec = 1'b0;
      issue(p, 1);
      chk(req_ready == 1'b0, "R10 busy during request", int'(req_ready), 0);
      repeat (20) @(negedge clk);
      chk(grant == 1'b0, "R6 no grant while speculative", int'(grant), 0);
      chk((n_wr - wr0) == 0 && (n_rd - rd0) == 0, "R6 no memory op while speculative",
          n_wr - wr0, 0);
      nonspec = 1'b1;
      wait_res(code);
      release_res();
      chk(code == 1, "R6 grant once non-speculative", code, 1);
      chk(mem_pte == 16'hC3C7, "R6 D set after commit", int'(mem_pte), 16'hC3C7);

      // R9: abort during the stall drops the store with no write
      host_set(p, 0);
      wr0 = n_wr;
      nonspec = 1'b0;
      issue(p, 1);
      repeat (5) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      repeat (10) @(negedge clk);
      chk(req_ready == 1'b1 && !grant && !fault, "R9 stalled store dropped", int'(req_ready), 1);
      chk((n_wr - wr0) == 0 && mem_pte == p, "R9 no write after stall abort", n_wr - wr0, 0);
      nonspec = 1'b0;

      // R6: speculative load may set A
      p = 16'hC303;
      host_set(p, 0);
      wr0 = n_wr;
      issue(p, 0);
      wait_res(code);
      release_res();
      chk(code == 1 && (n_wr - wr0) == 1, "R6 speculative A update", code, 1);
      chk(mem_pte == 16'hC343, "R6 only A set", int'(mem_pte), 16'hC343);
      nonspec = 1'b1;

      // R4: leaf becomes invalid between walk and update
      p = 16'hC307;
      host_set(p & ~16'h0001, 0);
      wr0 = n_wr; rd0 = n_rd;
      issue(p, 0);
      wait_res(code);
      release_res();
      chk(code == 2, "R4 fault on invalidated leaf", code, 2);
      chk((n_rd - rd0) == 1 && (n_wr - wr0) == 0, "R4 re-read without write", n_wr - wr0, 0);

      // R4: re-read shows write without read
      host_set(16'hC305, 0);
      wr0 = n_wr;
      issue(p, 1);
      wait_res(code);
      release_res();
      chk(code == 2 && (n_wr - wr0) == 0, "R4 fault on W-without-R re-read", code, 2);

      // R5: another agent already set the flags
      host_set(16'hC3C7, 0);
      wr0 = n_wr; rd0 = n_rd;
      issue(p, 1);
      wait_res(code);
      release_res();
      chk(code == 1 && (n_wr - wr0) == 0, "R5 no write when re-read has flags", n_wr - wr0, 0);
      chk((n_rd - rd0) == 1, "R5 one re-read", n_rd - rd0, 1);

      // R8: one mismatch then success
      host_set(p, 1);
      wr0 = n_wr; rd0 = n_rd;
      issue(p, 1);
      wait_res(code);
      release_res();
      chk(code == 1, "R8 grant after one retry", code, 1);
      chk((n_wr - wr0) == 2 && (n_rd - rd0) == 2, "R8 two reads two writes", n_wr - wr0, 2);
      chk(mem_pte == 16'hC3C7, "R8 entry updated", int'(mem_pte), 16'hC3C7);

      // R8: exhaustion
      host_set(p, MAX_TRIES);
      wr0 = n_wr;
      issue(p, 0);
      wait_res(code);
      chk(code == 3, "R8 retry exhausted", code, 3);
      repeat (3) @(negedge clk);
      chk(retry_fail == 1'b1, "R7 result held until ack", int'(retry_fail), 1);
      release_res();
      chk((n_wr - wr0) == MAX_TRIES && mem_pte == p, "R8 attempts and entry untouched",
          n_wr - wr0, MAX_TRIES);

      // R9: abort after grant keeps flags and issues nothing more
      host_set(p, 0);
      issue(p, 0);
      wait_res(code);
      chk(code == 1, "R9 grant before abort", code, 1);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      wr0 = n_wr; rd0 = n_rd;
      chk(grant == 1'b0 && req_ready == 1'b1, "R9 access dropped", int'(grant), 0);
      repeat (10) @(negedge clk);
      chk((n_wr - wr0) == 0 && (n_rd - rd0) == 0, "R9 no traffic after abort", n_wr - wr0, 0);
      chk(mem_pte == 16'hC347, "R9 A stays set", int'(mem_pte), 16'hC347);

      chk(viol_ack == 0, "R7 grant never before write ack", viol_ack, 0);
      chk(viol_ready == 0, "R10 ready never with result", viol_ready, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule